// File: doc/BRIEF.md
# Prioritized Interrupt Source Arbiter

This block tracks up to 128 interrupt sources and presents the CPU core with one winning source and its priority level. Every source has a record made of a pending bit and a 4-bit priority. Sources are named by an event code, which is the record index multiplied by 0x20, so the codes cover 0x000 to 0xFE0. Peripherals raise and drop their requests through a single event port. Software programs two priority-assignment registers.

Priorities come from three places. A group of fifteen external request lines has a fixed descending ladder. Three timer sources take nibbles of a 16-bit timer priority register. Four serial-port sources share one nibble of a 32-bit group priority register. Every other source has priority 0, and raising one of them is reported as a fault.

A raise updates the winner at once when the new source outranks the current level. Dropping a pending source clears the winner and starts a rescan. The rescan visits one record per clock, from index 0 upward. While it runs the event port is stalled.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the outputs are idle: win_valid, win_code, win_level, busy and prio_fault are 0 and ev_ready is 1. The timer priority register resets to 0x0000. The group priority register resets to 0x33333333, so serial sources start at level 3 and timer sources start at 0.
- R2: External source k (k = 0..14, record index 16+k, event code 0x200+k*0x20) has the fixed priority 15-k.
- R3: Timer sources 0, 1 and 2 have record indices 32, 33 and 34. They take their priority from timer register bits 15:12, 11:8 and 7:4 respectively. The register is written with cfg_we=1 and cfg_sel=0 from cfg_wdata[15:0].
- R4: Serial sources at record indices 56 to 59 all take their priority from group register bits 19:16. The register is written with cfg_we=1 and cfg_sel=1.
- R5: An event is accepted when ev_valid and ev_ready are both high. A raise is ev_kind=0. An accepted raise sets the source's pending bit. The source becomes the winner, visible in the next cycle, when no winner exists or when its priority is strictly greater than win_level. Otherwise the winner is unchanged.
- R6: win_code equals the winning record index times 0x20. When no source is the winner, win_valid is 0 and win_code and win_level are 0.
- R7: A drop is ev_kind=1. An accepted drop of a pending source clears its pending bit. In the next cycle win_valid is 0 and busy is 1, and busy then stays high for exactly 128 cycles. After that the winner is the pending source with the highest priority above 0, and ties go to the lowest index.
- R8: A drop of a source that is not pending has no effect. The winner is unchanged and busy stays 0.
- R9: An accepted raise of a source whose priority is 0 pulses prio_fault for one cycle and leaves the winner unchanged. A priority-0 source never becomes the winner.
- R10: Writing a priority register keeps every pending bit and does not change the current win_level. The new priorities take effect at the next raise or rescan.
- R11: While busy is 1, ev_ready is 0 and events on the port are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 1 | 0 = raise, 1 = drop |
| ev_idx | input | 7 | Source record index (event code / 0x20) |
| ev_ready | output | 1 | Event port can accept (low during rescan) |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_sel | input | 1 | 0 = timer priority register, 1 = group priority register |
| cfg_wdata | input | 32 | Write data |
| busy | output | 1 | Rescan in progress |
| win_valid | output | 1 | A winning source exists |
| win_code | output | 12 | Winning event code |
| win_level | output | 4 | Winning priority level |
| prio_fault | output | 1 | One-cycle pulse: a priority-0 source was raised |

## Verification
A corrupted pending bit stays hidden until the next rescan. At that point the port shows a wrong winner, or a winner where none should be, 129 cycles after the drop. A wrong priority for a source shows up in the cycle after that source is raised, because it wins or loses against the current level. A scan counter that stops early or wraps changes the busy length and can skip the high-index serial sources. For that reason the bench counts the busy cycles and places winners and ties both low and high in the index range.

// File: rtl/irq_arb_pkg.sv
// Shared definitions for the interrupt source arbiter.
// Assumes: event kinds are encoded on a single bit at the block edge.
package irq_arb_pkg;
    typedef enum logic {
        EV_RAISE = 1'b0,
        EV_DROP  = 1'b1
    } ev_kind_e;

    localparam int unsigned PRIO_W = 4;
endpackage

// File: rtl/irq_prio_regs.sv
// Priority-assignment registers: a 16-bit timer register and a 32-bit
// group register, both written whole by a single strobe.
// Assumes: no read path is needed; cfg_sel picks the target register.
module irq_prio_regs #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned TMR_W     = 16,
    parameter logic [TMR_W-1:0]  TMR_RST = '0,
    parameter logic [DATA_W-1:0] GRP_RST = 32'h3333_3333
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [TMR_W-1:0]  tmr_reg,
    output logic [DATA_W-1:0] grp_reg
);
    // Timer priority register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_reg <= TMR_RST;
        end else if (cfg_we && !cfg_sel) begin
            tmr_reg <= cfg_wdata[TMR_W-1:0];
        end
    end

    // Group priority register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_reg <= GRP_RST;
        end else if (cfg_we && cfg_sel) begin
            grp_reg <= cfg_wdata;
        end
    end
endmodule

// File: rtl/irq_prio_map.sv
// Builds the per-source priority table from the fixed external ladder,
// the timer nibbles and the shared serial nibble; other sources get 0.
// Assumes: the source ranges do not overlap and fit in N_SRC.
module irq_prio_map
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SRC     = 128,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned TMR_W     = 16,
    parameter int unsigned EXT_BASE  = 16,
    parameter int unsigned EXT_COUNT = 15,
    parameter int unsigned TMR_BASE  = 32,
    parameter int unsigned TMR_COUNT = 3,
    parameter int unsigned SER_BASE  = 56,
    parameter int unsigned SER_COUNT = 4,
    parameter int unsigned SER_LSB   = 16
) (
    input  logic [TMR_W-1:0]             tmr_reg,
    input  logic [DATA_W-1:0]            grp_reg,
    output logic [N_SRC-1:0][PRIO_W-1:0] prio_tab
);
    localparam int unsigned PRIO_MAX = (1 << PRIO_W) - 1;
    localparam int unsigned TMR_MSB  = TMR_W - 1;

    // Register bits that feed no source are collected here on purpose.
    logic unused_fields;
    assign unused_fields = ^{tmr_reg, grp_reg};

    // One priority selection per source, picked at elaboration.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        if (s >= EXT_BASE && s < EXT_BASE + EXT_COUNT) begin : g_ext
            assign prio_tab[s] = PRIO_W'(PRIO_MAX - (s - EXT_BASE));
        end else if (s >= TMR_BASE && s < TMR_BASE + TMR_COUNT) begin : g_tmr
            assign prio_tab[s] =
                tmr_reg[TMR_MSB - (s - TMR_BASE) * PRIO_W -: PRIO_W];
        end else if (s >= SER_BASE && s < SER_BASE + SER_COUNT) begin : g_ser
            assign prio_tab[s] = grp_reg[SER_LSB +: PRIO_W];
        end else begin : g_none
            assign prio_tab[s] = '0;
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Pending bit per source: set by an accepted raise, cleared by an
// accepted drop of a pending source.
// Assumes: set and clear never arrive in the same cycle.
module irq_pend_bank #(
    parameter int unsigned N_SRC = 128,
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] idx,
    output logic [N_SRC-1:0] pend
);
    // Pending bit storage, one flop per source.
    for (genvar s = 0; s < N_SRC; s++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[s] <= 1'b0;
            end else if (set_en && idx == IDX_W'(s)) begin
                pend[s] <= 1'b1;
            end else if (clr_en && idx == IDX_W'(s)) begin
                pend[s] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_win_scan.sv
// Holds the current winner. It updates the winner directly on a raise
// and rebuilds it with a one-record-per-clock scan after a drop. A later
// record replaces the candidate only on a strictly higher priority.
// Assumes: raise and drop are only issued while not busy.
module irq_win_scan
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SRC = 128,
    parameter int unsigned IDX_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         do_raise,
    input  logic                         do_drop,
    input  logic [IDX_W-1:0]             ev_idx,
    input  logic [PRIO_W-1:0]            ev_prio,
    input  logic [N_SRC-1:0]             pend,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_tab,
    output logic                         busy,
    output logic                         win_valid,
    output logic [IDX_W-1:0]             win_idx,
    output logic [PRIO_W-1:0]            win_lvl,
    output logic                         fault
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);

    logic [IDX_W-1:0]  scan_idx;
    logic              cand_valid;
    logic [IDX_W-1:0]  cand_idx;
    logic [PRIO_W-1:0] cand_lvl;
    logic              nxt_valid;
    logic [IDX_W-1:0]  nxt_idx;
    logic [PRIO_W-1:0] nxt_lvl;
    logic [PRIO_W-1:0] scan_prio;
    logic              scan_hit;
    logic              raise_wins;

    // Compare the record under the scan pointer with the candidate.
    always_comb begin
        scan_prio = prio_tab[scan_idx];
        scan_hit  = pend[scan_idx] && (scan_prio > cand_lvl);
        nxt_valid = cand_valid;
        nxt_idx   = cand_idx;
        nxt_lvl   = cand_lvl;
        if (scan_hit) begin
            nxt_valid = 1'b1;
            nxt_idx   = scan_idx;
            nxt_lvl   = scan_prio;
        end
    end

    // Decide whether a raised source takes over the winner.
    always_comb begin
        raise_wins = (ev_prio != '0) && (!win_valid || ev_prio > win_lvl);
    end

    // Winner, candidate and scan pointer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            scan_idx   <= '0;
            cand_valid <= 1'b0;
            cand_idx   <= '0;
            cand_lvl   <= '0;
            win_valid  <= 1'b0;
            win_idx    <= '0;
            win_lvl    <= '0;
        end else if (do_drop) begin
            busy       <= 1'b1;
            scan_idx   <= '0;
            cand_valid <= 1'b0;
            cand_idx   <= '0;
            cand_lvl   <= '0;
            win_valid  <= 1'b0;
            win_idx    <= '0;
            win_lvl    <= '0;
        end else if (do_raise) begin
            if (raise_wins) begin
                win_valid <= 1'b1;
                win_idx   <= ev_idx;
                win_lvl   <= ev_prio;
            end
        end else if (busy) begin
            if (scan_idx == LAST_IDX) begin
                busy      <= 1'b0;
                win_valid <= nxt_valid;
                win_idx   <= nxt_idx;
                win_lvl   <= nxt_lvl;
            end else begin
                scan_idx   <= scan_idx + 1'b1;
                cand_valid <= nxt_valid;
                cand_idx   <= nxt_idx;
                cand_lvl   <= nxt_lvl;
            end
        end
    end

    // One-cycle fault pulse for a raise of an unprioritized source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else begin
            fault <= do_raise && (ev_prio == '0);
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Top of the interrupt source arbiter: the event port, the priority
// registers, the pending bank and the winner/rescan engine.
// Assumes: callers hold an event until ev_ready is seen high.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SRC     = 128,
    parameter int unsigned CODE_STEP = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned TMR_W     = 16,
    parameter int unsigned EXT_BASE  = 16,
    parameter int unsigned EXT_COUNT = 15,
    parameter int unsigned TMR_BASE  = 32,
    parameter int unsigned TMR_COUNT = 3,
    parameter int unsigned SER_BASE  = 56,
    parameter int unsigned SER_COUNT = 4,
    parameter int unsigned SER_LSB   = 16,
    parameter int unsigned IDX_W     = $clog2(N_SRC),
    parameter int unsigned CODE_W    = IDX_W + $clog2(CODE_STEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_kind,
    input  logic [IDX_W-1:0]  ev_idx,
    output logic              ev_ready,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              busy,
    output logic              win_valid,
    output logic [CODE_W-1:0] win_code,
    output logic [PRIO_W-1:0] win_level,
    output logic              prio_fault
);
    localparam int unsigned STEP_SH = $clog2(CODE_STEP);

    logic [TMR_W-1:0]             tmr_reg;
    logic [DATA_W-1:0]            grp_reg;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_tab;
    logic [N_SRC-1:0]             pend;
    logic                         ev_acc;
    logic                         do_raise;
    logic                         do_drop;
    logic [IDX_W-1:0]             win_idx;

    // Event acceptance and decoding into raise / effective drop.
    always_comb begin
        ev_ready = !busy;
        ev_acc   = ev_valid && ev_ready;
        do_raise = ev_acc && (ev_kind_e'(ev_kind) == EV_RAISE);
        do_drop  = ev_acc && (ev_kind_e'(ev_kind) == EV_DROP) && pend[ev_idx];
    end

    // Event code is the record index scaled by the code step.
    always_comb begin
        win_code = win_valid ? (CODE_W'(win_idx) << STEP_SH) : '0;
    end

    irq_prio_regs #(
        .DATA_W (DATA_W),
        .TMR_W  (TMR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tmr_reg   (tmr_reg),
        .grp_reg   (grp_reg)
    );

    irq_prio_map #(
        .N_SRC     (N_SRC),
        .DATA_W    (DATA_W),
        .TMR_W     (TMR_W),
        .EXT_BASE  (EXT_BASE),
        .EXT_COUNT (EXT_COUNT),
        .TMR_BASE  (TMR_BASE),
        .TMR_COUNT (TMR_COUNT),
        .SER_BASE  (SER_BASE),
        .SER_COUNT (SER_COUNT),
        .SER_LSB   (SER_LSB)
    ) u_map (
        .tmr_reg  (tmr_reg),
        .grp_reg  (grp_reg),
        .prio_tab (prio_tab)
    );

    irq_pend_bank #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (do_raise),
        .clr_en (do_drop),
        .idx    (ev_idx),
        .pend   (pend)
    );

    irq_win_scan #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_raise  (do_raise),
        .do_drop   (do_drop),
        .ev_idx    (ev_idx),
        .ev_prio   (prio_tab[ev_idx]),
        .pend      (pend),
        .prio_tab  (prio_tab),
        .busy      (busy),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_level),
        .fault     (prio_fault)
    );
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
// Property checker for the interrupt source arbiter, bound to the top.
// Assumes: the bound scope provides the pending vector named pend.
module irq_prio_arbiter_chk #(
    parameter int unsigned N_SRC   = 128,
    parameter int unsigned IDX_W   = 7,
    parameter int unsigned CODE_W  = 12,
    parameter int unsigned STEP_SH = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_kind,
    input logic [IDX_W-1:0]  ev_idx,
    input logic              ev_ready,
    input logic              busy,
    input logic              win_valid,
    input logic [CODE_W-1:0] win_code,
    input logic [3:0]        win_level,
    input logic              prio_fault,
    input logic [N_SRC-1:0]  pend
);
    logic acc_raise;
    logic acc_drop;
    assign acc_raise = ev_valid && ev_ready && !ev_kind;
    assign acc_drop  = ev_valid && ev_ready && ev_kind;

    AST_RAISE_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_raise && win_valid |=> win_level >= $past(win_level)); // R5
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend[IDX_W'(win_code >> STEP_SH)]); // R6
    AST_DROP_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_drop && pend[ev_idx] |=> busy && !win_valid); // R7
    AST_DROP_IDLE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_drop && !pend[ev_idx] |=> !busy && win_code == $past(win_code)); // R8
    AST_WIN_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> win_level != 4'd0); // R9
    AST_FAULT_FROM_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        prio_fault |-> $past(acc_raise)); // R9
    AST_SCAN_STALLS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ev_ready && !win_valid); // R11
    AST_SCAN_FREEZES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> pend == $past(pend)); // R11
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
    .N_SRC   (N_SRC),
    .IDX_W   (IDX_W),
    .CODE_W  (CODE_W),
    .STEP_SH ($clog2(CODE_STEP))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_idx     (ev_idx),
    .ev_ready   (ev_ready),
    .busy       (busy),
    .win_valid  (win_valid),
    .win_code   (win_code),
    .win_level  (win_level),
    .prio_fault (prio_fault),
    .pend       (pend)
);

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_kind = 1'b0;
    logic [6:0]  ev_idx = '0;
    logic        ev_ready;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        busy;
    logic        win_valid;
    logic [11:0] win_code;
    logic [3:0]  win_level;
    logic        prio_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_idx(ev_idx), .ev_ready(ev_ready), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .busy(busy),
        .win_valid(win_valid), .win_code(win_code), .win_level(win_level),
        .prio_fault(prio_fault)
    );

    // op: 0 raise, 1 drop, 2 write timer register, 3 write group register
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  idx;
        logic [31:0] data;
        logic        ev;
        logic [11:0] ec;
        logic [3:0]  el;
        logic        ef;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'd56, 32'h0,        1'b1, 12'h700, 4'd3,  1'b0, 4'd4},  // R4 serial at reset level
        '{2'd0, 7'd57, 32'h0,        1'b1, 12'h700, 4'd3,  1'b0, 4'd5},  // R5 equal level keeps winner
        '{2'd0, 7'd32, 32'h0,        1'b1, 12'h700, 4'd3,  1'b1, 4'd9},  // R9 timer at prio 0
        '{2'd2, 7'd0,  32'h5A60,     1'b1, 12'h700, 4'd3,  1'b0, 4'd3},  // R3 program timers
        '{2'd0, 7'd34, 32'h0,        1'b1, 12'h440, 4'd6,  1'b0, 4'd3},  // R3 timer2 = 6
        '{2'd0, 7'd33, 32'h0,        1'b1, 12'h420, 4'd10, 1'b0, 4'd3},  // R3 timer1 = 10
        '{2'd0, 7'd20, 32'h0,        1'b1, 12'h280, 4'd11, 1'b0, 4'd2},  // R2 ext4 = 11
        '{2'd1, 7'd20, 32'h0,        1'b1, 12'h420, 4'd10, 1'b0, 4'd7},  // R7 rescan
        '{2'd1, 7'd33, 32'h0,        1'b1, 12'h440, 4'd6,  1'b0, 4'd7},  // R7 rescan
        '{2'd3, 7'd0,  32'h00090000, 1'b1, 12'h440, 4'd6,  1'b0, 4'd10}, // R10 level latched
        '{2'd1, 7'd34, 32'h0,        1'b1, 12'h700, 4'd9,  1'b0, 4'd10}, // R10 new serial prio, tie low
        '{2'd1, 7'd40, 32'h0,        1'b1, 12'h700, 4'd9,  1'b0, 4'd8},  // R8 drop idle source
        '{2'd1, 7'd56, 32'h0,        1'b1, 12'h720, 4'd9,  1'b0, 4'd7},  // R7
        '{2'd1, 7'd57, 32'h0,        1'b1, 12'h400, 4'd5,  1'b0, 4'd7},  // R7
        '{2'd0, 7'd30, 32'h0,        1'b1, 12'h400, 4'd5,  1'b0, 4'd2},  // R2 ext14 = 1 loses
        '{2'd1, 7'd32, 32'h0,        1'b1, 12'h3C0, 4'd1,  1'b0, 4'd2},  // R2 ext14 alone
        '{2'd1, 7'd30, 32'h0,        1'b0, 12'h000, 4'd0,  1'b0, 4'd6},  // R6 none pending
        '{2'd0, 7'd16, 32'h0,        1'b1, 12'h200, 4'd15, 1'b0, 4'd2},  // R2 ext0 = 15
        '{2'd0, 7'd0,  32'h0,        1'b1, 12'h200, 4'd15, 1'b1, 4'd9},  // R9
        '{2'd1, 7'd0,  32'h0,        1'b1, 12'h200, 4'd15, 1'b0, 4'd7},  // R7
        '{2'd1, 7'd16, 32'h0,        1'b0, 12'h000, 4'd0,  1'b0, 4'd6}   // R6
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 300 && busy; g++) @(negedge clk);
    endtask

    task automatic send_ev(input logic kind, input logic [6:0] idx);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = kind; ev_idx = idx;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic check_win(input string req, input logic v,
                             input logic [11:0] c, input logic [3:0] l);
        chk(req, "win_valid", 32'(win_valid), 32'(v));
        chk(req, "win_code",  32'(win_code),  32'(c));
        chk(req, "win_level", 32'(win_level), 32'(l));
    endtask

    initial begin
        #800000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        string tag;
        int bcount;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_win("R1", 1'b0, 12'h0, 4'd0);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "prio_fault", 32'(prio_fault), 32'd0);
        chk("R1", "ev_ready", 32'(ev_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            @(negedge clk);
            if (VECS[i].op[1]) begin
                cfg_we = 1'b1; cfg_sel = VECS[i].op[0]; cfg_wdata = VECS[i].data;
            end else begin
                ev_valid = 1'b1; ev_kind = VECS[i].op[0]; ev_idx = VECS[i].idx;
            end
            @(negedge clk);
            cfg_we = 1'b0; ev_valid = 1'b0;
            chk(tag, "prio_fault", 32'(prio_fault), 32'(VECS[i].ef));
            wait_idle();
            check_win(tag, VECS[i].ev, VECS[i].ec, VECS[i].el);
        end

        // R11 / R7: stall during rescan and exact busy length
        send_ev(1'b0, 7'd17);
        check_win("R2", 1'b1, 12'h220, 4'd14);
        send_ev(1'b0, 7'd18);
        check_win("R5", 1'b1, 12'h220, 4'd14);
        send_ev(1'b1, 7'd18);
        chk("R11", "ev_ready", 32'(ev_ready), 32'd0);
        chk("R7", "busy", 32'(busy), 32'd1);
        bcount = 0;
        for (int g = 0; g < 300 && busy; g++) begin
            bcount++;
            if (g == 0) begin
                ev_valid = 1'b1; ev_kind = 1'b0; ev_idx = 7'd16;
            end else begin
                ev_valid = 1'b0;
            end
            @(negedge clk);
        end
        ev_valid = 1'b0;
        chk("R7", "busy cycles", 32'(bcount), 32'd128);
        check_win("R11", 1'b1, 12'h220, 4'd14);
        send_ev(1'b1, 7'd17);
        wait_idle();
        check_win("R11", 1'b0, 12'h0, 4'd0);   // source 16 never became pending

        // R8: drop of an idle source starts no scan
        send_ev(1'b1, 7'd5);
        chk("R8", "busy", 32'(busy), 32'd0);
        check_win("R8", 1'b0, 12'h0, 4'd0);

        // R1: reset mid-run restores register defaults
        send_ev(1'b0, 7'd20);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_win("R1", 1'b0, 12'h0, 4'd0);
        send_ev(1'b0, 7'd57);
        check_win("R1", 1'b1, 12'h720, 4'd3);
        send_ev(1'b0, 7'd33);
        chk("R1", "prio_fault", 32'(prio_fault), 32'd1);
        check_win("R1", 1'b1, 12'h720, 4'd3);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule